// File: doc/BRIEF.md
# Caller-ID FSK Bit Stream Sequencer

This block produces the serial bit sequence of an on-hook caller-ID message and hands it, one bit at a time, to a downstream FSK modulator. A host programs four phase lengths (seizure, mark, flag, data), a two-bit channel select and an enable bit through a small register port. It also fills a 64-byte message buffer through a separate write port. A start pulse then runs the message out.

The message has a fixed phase order. First come alternating `0`,`1` seizure bits, then a run of mark ones, then the message bytes. Each byte is framed with a start and a stop bit, and optional runs of flag ones sit between consecutive bytes. A baud strobe from the modulator's timing logic advances the stream by exactly one bit. The chosen channel index is presented with every bit, so the modulator can steer the tones to one of four lines. Lengths and channel are captured when the start is accepted. The host may therefore reprogram the registers for the next message while the current one is still being sent.

Top module: `cid_fsk_seq`

## Requirements
- R1: After reset all four length registers and the control register read 0. `tx_bit` is 1, `tx_valid`, `tx_done` and `busy` are 0, and `tx_chan` is 0.
- R2: Register addresses are: 0 seizure, 1 mark, 2 flag, 3 data length, 4 control. Control has bit 0 as the enable and bits 2:1 as the channel (00 = channel 1 … 11 = channel 4). Written values read back unchanged on `cfg_rdata`, including data lengths above 64. Unused control bits and addresses 5 to 7 read 0.
- R3: With seizure value S, the message begins with 4·S bits (2·S pairs) alternating `0`,`1`, starting with `0`.
- R4: With mark value M, exactly M ones follow the seizure bits.
- R5: Each message byte is sent as 10 bits: `0`, the eight data bits LSB first, then `1`. Bytes come from buffer entries 0, 1, 2 … in order.
- R6: With flag value F, exactly F ones are sent between each pair of consecutive bytes, and none before the first byte or after the last.
- R7: A data length above 64 sends exactly 64 bytes.
- R8: A zero length skips its phase entirely. With all lengths zero, the first strobe after start gives the done pulse without any valid bit.
- R9: Each `baud_tick` outputs the next bit with `tx_valid` high. Bits hold between strobes. On the strobe after the last bit, `tx_done` pulses for one cycle, `tx_valid` drops, `tx_bit` returns to 1 and `busy` falls.
- R10: While the enable is 0 a start pulse is ignored. Clearing the enable during a message stops it within two cycles of the register write: `tx_valid` and `busy` become 0 and `tx_bit` becomes 1, with no done pulse.
- R11: Lengths and channel are latched when start is accepted. Register writes during a message do not change its bits, and `tx_chan` keeps the latched channel.
- R12: A start pulse while `busy` is high is ignored and does not restart the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` (combinational) |
| buf_we | input | 1 | Message buffer write strobe |
| buf_addr | input | 6 | Message buffer entry |
| buf_wdata | input | 8 | Message buffer write data |
| start_req | input | 1 | Start command pulse |
| baud_tick | input | 1 | One-cycle strobe per output bit |
| tx_bit | output | 1 | Serial bit to the modulator (1 when idle) |
| tx_valid | output | 1 | A message bit is being presented |
| tx_chan | output | 2 | Latched channel index |
| tx_done | output | 1 | One-cycle pulse at message end |
| busy | output | 1 | A message is in progress |

## Verification
The bench targets the phase boundaries. A design that sized the seizure run by pairs rather than bits would come up short by half. A design that leaked a flag run after the last byte would show extra ones before done. The all-zero message must end on its first strobe. A data length of 200 must stop at 64 bytes rather than wrap or index past the buffer. An abort must leave the line at 1 with no done pulse. A mid-message register write or second start must change neither the remaining bits nor the channel.

// File: rtl/cid_fsk_pkg.sv
package cid_fsk_pkg;

    localparam int LEN_W      = 8;
    localparam int BUF_DEPTH  = 64;
    localparam int BUF_AW     = $clog2(BUF_DEPTH);
    localparam int IDX_W      = BUF_AW + 1;
    localparam int CNT_W      = LEN_W + 2;
    localparam int FRAME_BITS = 10;
    localparam int CHAN_W     = 2;
    localparam int ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] A_SEIZE = 3'd0;
    localparam logic [ADDR_W-1:0] A_MARK  = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DLEN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SEIZE, PH_MARK, PH_BYTE, PH_FLAG, PH_END
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] seize;
        logic [LEN_W-1:0] mark;
        logic [LEN_W-1:0] flag;
        logic [LEN_W-1:0] dlen;
    } lens_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              en;
    } ctrl_t;

    function automatic logic [IDX_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
        if (v > LEN_W'(BUF_DEPTH))
            return IDX_W'(BUF_DEPTH);
        return IDX_W'(v);
    endfunction

endpackage

// File: rtl/cid_cfg_regs.sv
module cid_cfg_regs
    import cid_fsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  wdata,
    output logic [LEN_W-1:0]  rdata,
    output lens_t             lens,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lens <= '0;
            ctrl <= '0;
        end else if (we) begin
            case (addr)
                A_SEIZE: lens.seize <= wdata;
                A_MARK:  lens.mark  <= wdata;
                A_FLAG:  lens.flag  <= wdata;
                A_DLEN:  lens.dlen  <= wdata;
                A_CTRL:  ctrl       <= wdata[$bits(ctrl_t)-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_SEIZE: rdata = lens.seize;
            A_MARK:  rdata = lens.mark;
            A_FLAG:  rdata = lens.flag;
            A_DLEN:  rdata = lens.dlen;
            A_CTRL:  rdata = LEN_W'(ctrl);
            default: rdata = '0;
        endcase
    end

    logic unused_hi;
    assign unused_hi = &{1'b0, wdata[LEN_W-1:$bits(ctrl_t)]};

    always_ff @(posedge clk) begin
        if (!rst) begin
            assert_ctrl_upper_zero_R2: assert (addr != A_CTRL || rdata[LEN_W-1:$bits(ctrl_t)] == '0)
                else $error("control readback upper bits not zero");
        end
    end
endmodule

// File: rtl/cid_msg_buf.sv
module cid_msg_buf #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cid_bit_seq.sv
module cid_bit_seq
    import cid_fsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic              tick,
    input  lens_t             lens,
    input  logic [CHAN_W-1:0] chan,
    output logic [BUF_AW-1:0] buf_raddr,
    input  logic [7:0]        buf_rdata,
    output logic              tx_bit,
    output logic              tx_valid,
    output logic              tx_done,
    output logic [CHAN_W-1:0] tx_chan,
    output logic              busy
);
    phase_e            phase, nxt_phase, first_phase;
    logic [CNT_W-1:0]  pos, nxt_pos, pos_inc, phase_len;
    logic [IDX_W-1:0]  byte_idx, nxt_idx, idx_inc;
    logic [CNT_W-1:0]  seize_bits_q;
    logic [LEN_W-1:0]  mark_q, flag_q;
    logic [IDX_W-1:0]  dlen_q, dlen_in;
    logic              cur_bit, last_in_phase;

    assign dlen_in   = clamp_len(lens.dlen);
    assign busy      = (phase != PH_IDLE);
    assign buf_raddr = byte_idx[BUF_AW-1:0];
    assign pos_inc   = pos + 1'b1;
    assign idx_inc   = byte_idx + 1'b1;

    always_comb begin
        if (lens.seize != '0)      first_phase = PH_SEIZE;
        else if (lens.mark != '0)  first_phase = PH_MARK;
        else if (dlen_in != '0)    first_phase = PH_BYTE;
        else                       first_phase = PH_END;
    end

    always_comb begin
        case (phase)
            PH_SEIZE: begin cur_bit = pos[0]; phase_len = seize_bits_q; end
            PH_MARK:  begin cur_bit = 1'b1;   phase_len = CNT_W'(mark_q); end
            PH_FLAG:  begin cur_bit = 1'b1;   phase_len = CNT_W'(flag_q); end
            PH_BYTE: begin
                phase_len = CNT_W'(FRAME_BITS);
                if (pos == '0)
                    cur_bit = 1'b0;
                else if (pos == CNT_W'(FRAME_BITS - 1))
                    cur_bit = 1'b1;
                else
                    cur_bit = buf_rdata[pos[2:0] - 3'd1];
            end
            default: begin cur_bit = 1'b1; phase_len = '0; end
        endcase
    end

    assign last_in_phase = (pos_inc == phase_len);

    always_comb begin
        nxt_phase = phase;
        nxt_pos   = pos_inc;
        nxt_idx   = byte_idx;
        if (last_in_phase) begin
            nxt_pos = '0;
            case (phase)
                PH_SEIZE: nxt_phase = (mark_q != '0) ? PH_MARK
                                    : (dlen_q != '0) ? PH_BYTE : PH_END;
                PH_MARK:  nxt_phase = (dlen_q != '0) ? PH_BYTE : PH_END;
                PH_BYTE: begin
                    nxt_idx   = idx_inc;
                    nxt_phase = (idx_inc == dlen_q) ? PH_END
                              : (flag_q != '0)     ? PH_FLAG : PH_BYTE;
                end
                PH_FLAG:  nxt_phase = PH_BYTE;
                default:  nxt_phase = PH_END;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            pos          <= '0;
            byte_idx     <= '0;
            seize_bits_q <= '0;
            mark_q       <= '0;
            flag_q       <= '0;
            dlen_q       <= '0;
            tx_bit       <= 1'b1;
            tx_valid     <= 1'b0;
            tx_done      <= 1'b0;
            tx_chan      <= '0;
        end else begin
            tx_done <= 1'b0;
            if (!en) begin
                phase    <= PH_IDLE;
                tx_bit   <= 1'b1;
                tx_valid <= 1'b0;
            end else if (phase == PH_IDLE) begin
                if (start) begin
                    phase        <= first_phase;
                    pos          <= '0;
                    byte_idx     <= '0;
                    seize_bits_q <= {lens.seize, 2'b00};
                    mark_q       <= lens.mark;
                    flag_q       <= lens.flag;
                    dlen_q       <= dlen_in;
                    tx_chan      <= chan;
                end
            end else if (tick) begin
                if (phase == PH_END) begin
                    phase    <= PH_IDLE;
                    tx_done  <= 1'b1;
                    tx_valid <= 1'b0;
                    tx_bit   <= 1'b1;
                end else begin
                    tx_bit   <= cur_bit;
                    tx_valid <= 1'b1;
                    phase    <= nxt_phase;
                    pos      <= nxt_pos;
                    byte_idx <= nxt_idx;
                end
            end
        end
    end

    assert_idle_line_R9: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |-> tx_bit);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);
    assert_bit_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!tick && en && busy) |=> ($stable(tx_bit) && $stable(tx_valid)));
    assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!tx_valid && !busy));
    assert_seize_first_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (en && tick && phase == PH_SEIZE && pos == '0) |=> !tx_bit);
    assert_byte_cap_R7: assert property (@(posedge clk) disable iff (rst)
        byte_idx <= IDX_W'(BUF_DEPTH));
    assert_chan_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && en) |=> $stable(tx_chan));
endmodule

// File: rtl/cid_fsk_seq.sv
module cid_fsk_seq
    import cid_fsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              buf_we,
    input  logic [5:0]        buf_addr,
    input  logic [7:0]        buf_wdata,
    input  logic              start_req,
    input  logic              baud_tick,
    output logic              tx_bit,
    output logic              tx_valid,
    output logic [1:0]        tx_chan,
    output logic              tx_done,
    output logic              busy
);
    lens_t             lens;
    ctrl_t             ctrl;
    logic [BUF_AW-1:0] rd_addr;
    logic [7:0]        rd_byte;

    cid_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .lens  (lens),
        .ctrl  (ctrl)
    );

    cid_msg_buf #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_addr),
        .wdata (buf_wdata),
        .raddr (rd_addr),
        .rdata (rd_byte)
    );

    cid_bit_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .start     (start_req),
        .tick      (baud_tick),
        .lens      (lens),
        .chan      (ctrl.chan),
        .buf_raddr (rd_addr),
        .buf_rdata (rd_byte),
        .tx_bit    (tx_bit),
        .tx_valid  (tx_valid),
        .tx_done   (tx_done),
        .tx_chan   (tx_chan),
        .busy      (busy)
    );
endmodule

// File: tb/test_cid_fsk_seq.sv
`timescale 1ns/1ps
module test_cid_fsk_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       buf_we = 1'b0;
    logic [5:0] buf_addr = '0;
    logic [7:0] buf_wdata = '0;
    logic       start_req = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_bit, tx_valid, tx_done, busy;
    logic [1:0] tx_chan;

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [64];
    bit    exp_q [$];
    string tag_q [$];

    always #4 clk = ~clk;

    cid_fsk_seq i_cid_fsk_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .start_req(start_req),
        .baud_tick(baud_tick), .tx_bit(tx_bit), .tx_valid(tx_valid),
        .tx_chan(tx_chan), .tx_done(tx_done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic cfg_read_chk(input logic [2:0] a, input int exp, input string req);
        @(negedge clk); cfg_addr = a; #1;
        chk(cfg_rdata == exp[7:0], req, $sformatf("readback addr %0d", a), cfg_rdata, exp);
    endtask

    task automatic buf_write(input int a, input logic [7:0] d);
        @(negedge clk); buf_we = 1'b1; buf_addr = a[5:0]; buf_wdata = d;
        @(negedge clk); buf_we = 1'b0;
        shadow[a] = d;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); baud_tick = 1'b1;
        @(negedge clk); baud_tick = 1'b0;
    endtask

    function automatic int clamp64(input int v);
        return (v > 64) ? 64 : v;
    endfunction

    task automatic build_expected(input int sl, input int ml, input int fl, input int dl);
        int n;
        exp_q.delete(); tag_q.delete();
        for (int i = 0; i < 4 * sl; i++) begin exp_q.push_back(i % 2); tag_q.push_back("R3"); end
        for (int i = 0; i < ml; i++) begin exp_q.push_back(1'b1); tag_q.push_back("R4"); end
        n = clamp64(dl);
        for (int b = 0; b < n; b++) begin
            if (b > 0)
                for (int f = 0; f < fl; f++) begin exp_q.push_back(1'b1); tag_q.push_back("R6"); end
            exp_q.push_back(1'b0); tag_q.push_back("R5");
            for (int k = 0; k < 8; k++) begin exp_q.push_back(shadow[b][k]); tag_q.push_back("R5"); end
            exp_q.push_back(1'b1); tag_q.push_back("R5");
        end
    endtask

    // disturb >= 0: at that bit, reprogram registers and issue a second start (R11, R12)
    task automatic send_msg(input int sl, input int ml, input int fl, input int dl,
                            input int ch, input int disturb);
        cfg_write(3'd0, sl[7:0]);
        cfg_write(3'd1, ml[7:0]);
        cfg_write(3'd2, fl[7:0]);
        cfg_write(3'd3, dl[7:0]);
        cfg_write(3'd4, {5'd0, ch[1:0], 1'b1});
        build_expected(sl, ml, fl, dl);
        pulse_start();
        chk(busy == 1'b1 && tx_valid == 1'b0, "R9", "busy before first strobe",
            {busy, tx_valid}, 2);
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i == disturb) begin
                cfg_write(3'd0, 8'd9);
                cfg_write(3'd1, 8'd1);
                cfg_write(3'd2, 8'd0);
                cfg_write(3'd3, 8'd2);
                cfg_write(3'd4, {5'd0, ~ch[1:0], 1'b1});
                pulse_start();
                chk(busy == 1'b1, "R12", "busy after start while busy", busy, 1);
            end
            tick();
            chk(tx_valid == 1'b1 && tx_bit == exp_q[i], tag_q[i],
                $sformatf("bit %0d (valid,bit)", i), {tx_valid, tx_bit}, {1'b1, exp_q[i]});
            if (i == 0 || i == disturb)
                chk(tx_chan == ch[1:0], "R11", "tx_chan", tx_chan, ch[1:0]);
        end
        tick();
        chk(tx_done == 1'b1, exp_q.size() == 0 ? "R8" : "R9", "done pulse", tx_done, 1);
        chk(tx_valid == 1'b0 && tx_bit == 1'b1 && busy == 1'b0, "R9", "idle after done",
            {tx_valid, tx_bit, busy}, 3'b010);
        @(negedge clk);
        chk(tx_done == 1'b0, "R9", "done is one cycle", tx_done, 0);
    endtask

    task automatic load_random(input int n);
        for (int a = 0; a < n; a++) buf_write(a, 8'($urandom));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(tx_bit == 1'b1 && tx_valid == 1'b0 && tx_done == 1'b0 && busy == 1'b0,
            "R1", "outputs after reset", {tx_bit, tx_valid, tx_done, busy}, 4'b1000);
        chk(tx_chan == 2'd0, "R1", "tx_chan after reset", tx_chan, 0);
        for (int a = 0; a < 5; a++) cfg_read_chk(a[2:0], 0, "R1");

        // R2: readback, clamped length still reads raw
        cfg_write(3'd0, 8'hA5); cfg_read_chk(3'd0, 8'hA5, "R2");
        cfg_write(3'd1, 8'h3C); cfg_read_chk(3'd1, 8'h3C, "R2");
        cfg_write(3'd2, 8'hFF); cfg_read_chk(3'd2, 8'hFF, "R2");
        cfg_write(3'd3, 8'd200); cfg_read_chk(3'd3, 200, "R2");
        cfg_write(3'd4, 8'hFC); cfg_read_chk(3'd4, 8'h04, "R2");
        cfg_read_chk(3'd6, 0, "R2");

        // R10: start ignored while disabled (enable bit is 0 above)
        pulse_start();
        tick();
        chk(busy == 1'b0 && tx_valid == 1'b0 && tx_done == 1'b0, "R10",
            "start while disabled", {busy, tx_valid, tx_done}, 0);

        load_random(64);

        // R8: everything zero
        send_msg(0, 0, 0, 0, 0, -1);
        // R8: only data, no seizure/mark, no flags
        send_msg(0, 0, 0, 2, 1, -1);
        // R3/R4 only, no data
        send_msg(1, 3, 5, 0, 2, -1);
        // R6: one flag bit, several bytes
        send_msg(2, 2, 1, 4, 3, -1);
        // R7: clamp 200 -> 64 bytes
        send_msg(0, 0, 0, 200, 0, -1);
        // R7: exactly 65 -> 64, with flags
        send_msg(0, 1, 2, 65, 1, -1);
        // R11, R12: reprogram and re-start in the middle
        send_msg(2, 3, 2, 3, 2, 20);

        // random messages
        for (int r = 0; r < 6; r++) begin
            load_random(12);
            send_msg($urandom_range(0, 5), $urandom_range(0, 15), $urandom_range(0, 5),
                     $urandom_range(0, 12), $urandom_range(0, 3), -1);
        end

        // R10: abort in the middle
        cfg_write(3'd0, 8'd3);
        cfg_write(3'd1, 8'd4);
        cfg_write(3'd2, 8'd1);
        cfg_write(3'd3, 8'd3);
        cfg_write(3'd4, 8'h01);
        pulse_start();
        repeat (5) tick();
        chk(tx_valid == 1'b1 && busy == 1'b1, "R10", "running before abort",
            {tx_valid, busy}, 3);
        cfg_write(3'd4, 8'h00);
        @(negedge clk);
        chk(tx_valid == 1'b0 && busy == 1'b0 && tx_bit == 1'b1, "R10", "after abort",
            {tx_valid, busy, tx_bit}, 1);
        cfg_write(3'd4, 8'h01);
        tick();
        chk(tx_done == 1'b0 && tx_valid == 1'b0 && busy == 1'b0, "R10",
            "no resume or done after abort", {tx_done, tx_valid, busy}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule